// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

A watchdog timer peripheral on a single-cycle register port: 16-bit data, byte offsets, a write strobe that takes effect on the clock edge, and a read that decodes the address combinationally. A 15-bit down-counter counts in timer ticks. A prescaler produces one tick every `TICK_CYCLES` system clocks, which is 10 ms at the intended clock. Software keeps the system alive by writing a magic feed key. If the count runs out, the block pulses a system reset output, latches a coded timed-out status, reloads the last programmed timeout and keeps counting.

Every control action needs a specific 16-bit key. Stopping the timer takes two ordered key writes, and a separate key resumes it. Enable state, status and count read back as coded values. One tick before expiry the block raises an early-warning event that can be masked onto an interrupt line, and software can also force that event. A debug-mode input freezes the timer unless an override bit is set.

Top module: `key_wdt`

## Requirements
- R1: After reset the timer is stopped (offset 0x0C reads 0xDABE), status (0x10) reads 0x0000, the count (0x14) reads 0, the timeout (0x04) reads `DEF_TIMEOUT`, and both `irq_o` and `sys_rst_o` are low.
- R2: Writing 0xFEED to offset 0x00 while enabled loads the count from the timeout register and starts counting. Any other value, or any feed while stopped, leaves the count unchanged.
- R3: The timeout register at 0x04 keeps bits 14:0 of the written value, and bit 15 reads 0.
- R4: Once started, the count drops by one every `TICK_CYCLES` clocks, counted from the feed edge. With timeout T, expiry comes T*`TICK_CYCLES` clock edges after the feed, and `sys_rst_o` is high right after that edge.
- R5: At expiry `sys_rst_o` stays high for exactly `RST_CYCLES` clocks, and the count is reloaded with the timeout and keeps running.
- R6: The timer stops only when 0x2BAD is written to 0x08 and the very next register write puts 0xCAFE at 0x0C. A lone 0xCAFE, or one separated by any other write, has no effect. Offset 0x0C reads 0xDABE while stopped and 0x0000 while enabled.
- R7: Writing 0xACED to 0x1C re-enables a stopped timer, and the count then stays put until the next feed.
- R8: Expiry makes status read 0xCFE8 until 0xE8B4 is written to 0x10. Other values written there change nothing.
- R9: The count register returns the live count in bits 14:0. Bit 15 is 1 exactly in the clock before a tick changes the count, and 0 otherwise.
- R10: The tick that leaves one tick remaining sets the event bit (0x20 bit 0). Writing 1 to 0x28 bit 0 also sets it, and writing 1 to 0x20 bit 0 clears it. `irq_o` is the event ANDed with mask bit 0 at 0x24. Offset 0x28 reads 0.
- R11: Offset 0x18 reads `dbg_mode` in bit 1 and the override in bit 0. While `dbg_mode` is high and the override is 0, the count and prescaler hold, and neither the warning nor the reset fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, with `bus_sel` |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| dbg_mode | input | 1 | Debug mode active |
| irq_o | output | 1 | Early-warning interrupt |
| sys_rst_o | output | 1 | System reset pulse at expiry |

## Verification
The countdown is swept over timeouts 1 to 6 under a short tick. For each timeout the bench measures the exact edge of expiry, the edge of the warning and the reset width. This separates an off-by-one in the prescaler from one in the count compare, and shows that a timeout of 1 produces no warning. Wrong keys, a lone or interrupted disable pair, and feeds while stopped or frozen are each followed by a count or code read-back, which shows whether the attempt had any effect. Forced events are tried against both mask settings to separate the event bit from the interrupt gate.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 15;

  localparam logic [ADDR_W-1:0] A_FEED   = 6'h00;
  localparam logic [ADDR_W-1:0] A_TMO    = 6'h04;
  localparam logic [ADDR_W-1:0] A_DIS1   = 6'h08;
  localparam logic [ADDR_W-1:0] A_DIS2   = 6'h0C;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h10;
  localparam logic [ADDR_W-1:0] A_CNT    = 6'h14;
  localparam logic [ADDR_W-1:0] A_DBG    = 6'h18;
  localparam logic [ADDR_W-1:0] A_RESUME = 6'h1C;
  localparam logic [ADDR_W-1:0] A_EVT    = 6'h20;
  localparam logic [ADDR_W-1:0] A_MASK   = 6'h24;
  localparam logic [ADDR_W-1:0] A_FORCE  = 6'h28;

  localparam logic [DATA_W-1:0] K_FEED     = 16'hFEED;
  localparam logic [DATA_W-1:0] K_DIS1     = 16'h2BAD;
  localparam logic [DATA_W-1:0] K_DIS2     = 16'hCAFE;
  localparam logic [DATA_W-1:0] K_RESUME   = 16'hACED;
  localparam logic [DATA_W-1:0] K_CLEAR    = 16'hE8B4;
  localparam logic [DATA_W-1:0] C_STOPPED  = 16'hDABE;
  localparam logic [DATA_W-1:0] C_TIMEDOUT = 16'hCFE8;
endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
  parameter int TICK_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_q <= '0;
    else if (clr)        div_q <= '0;
    else if (run) begin
      if (div_q == LAST) div_q <= '0;
      else               div_q <= div_q + 1'b1;
    end
  end

  assign tick = run && !clr && (div_q == LAST);
endmodule

// File: rtl/kwdt_countdown.sv
module kwdt_countdown #(
  parameter int CW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] reload_val,
  input  logic          tick,
  output logic [CW-1:0] count,
  output logic          warn,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign warn   = tick && !load && (cnt_q == CW'(2));
  assign expire = tick && !load && (cnt_q <= CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= reload_val;
    else if (expire) cnt_q <= reload_val;
    else if (tick)   cnt_q <= cnt_q - 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int LW = $clog2(LEN + 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (trig)           left_q <= LW'(LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/key_wdt.sv
module key_wdt
  import kwdt_pkg::*;
#(
  parameter int TICK_CYCLES = 500000,
  parameter int RST_CYCLES  = 16,
  parameter int DEF_TIMEOUT = 6000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_mode,
  output logic              irq_o,
  output logic              sys_rst_o
);
  logic             en_q, run_q, arm_q, sts_q, ev_q, mask_q, ovr_q;
  logic [CNT_W-1:0] tmo_q;
  logic [CNT_W-1:0] count_q;
  logic             tick, warn, expire;

  logic wr;
  assign wr = bus_sel && bus_we;

  logic feed_ok, dis_ok, resume_ok, clear_ok, arm_set;
  assign feed_ok   = wr && bus_addr == A_FEED   && bus_wdata == K_FEED && en_q;
  assign arm_set   = wr && bus_addr == A_DIS1   && bus_wdata == K_DIS1;
  assign dis_ok    = wr && bus_addr == A_DIS2   && bus_wdata == K_DIS2 && arm_q;
  assign resume_ok = wr && bus_addr == A_RESUME && bus_wdata == K_RESUME;
  assign clear_ok  = wr && bus_addr == A_STAT   && bus_wdata == K_CLEAR;

  logic gated, active;
  assign gated  = dbg_mode && !ovr_q;
  assign active = en_q && run_q && !gated;

  kwdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) presc_i (
    .clk(clk), .rst_n(rst_n), .clr(feed_ok), .run(active), .tick(tick)
  );

  kwdt_countdown #(.CW(CNT_W)) cdown_i (
    .clk(clk), .rst_n(rst_n), .load(feed_ok), .reload_val(tmo_q),
    .tick(tick), .count(count_q), .warn(warn), .expire(expire)
  );

  kwdt_pulse #(.LEN(RST_CYCLES)) rstp_i (
    .clk(clk), .rst_n(rst_n), .trig(expire), .pulse(sys_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      sts_q  <= 1'b0;
      ev_q   <= 1'b0;
      mask_q <= 1'b0;
      ovr_q  <= 1'b0;
      tmo_q  <= CNT_W'(DEF_TIMEOUT);
    end else begin
      if (wr) arm_q <= arm_set;
      if (dis_ok) begin
        en_q  <= 1'b0;
        run_q <= 1'b0;
      end else if (resume_ok) begin
        en_q  <= 1'b1;
      end else if (feed_ok) begin
        run_q <= 1'b1;
      end
      if (expire)        sts_q <= 1'b1;
      else if (clear_ok) sts_q <= 1'b0;
      if (warn || (wr && bus_addr == A_FORCE && bus_wdata[0]))
        ev_q <= 1'b1;
      else if (wr && bus_addr == A_EVT && bus_wdata[0])
        ev_q <= 1'b0;
      if (wr && bus_addr == A_MASK) mask_q <= bus_wdata[0];
      if (wr && bus_addr == A_DBG)  ovr_q  <= bus_wdata[0];
      if (wr && bus_addr == A_TMO)  tmo_q  <= bus_wdata[CNT_W-1:0];
    end
  end

  assign irq_o = ev_q && mask_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TMO:  bus_rdata = {1'b0, tmo_q};
      A_DIS2: bus_rdata = en_q ? '0 : C_STOPPED;
      A_STAT: bus_rdata = sts_q ? C_TIMEDOUT : '0;
      A_CNT:  bus_rdata = {tick, count_q};
      A_DBG:  bus_rdata = {14'b0, dbg_mode, ovr_q};
      A_EVT:  bus_rdata = {15'b0, ev_q};
      A_MASK: bus_rdata = {15'b0, mask_q};
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/key_wdt_chk.sv
module key_wdt_chk #(
  parameter int RST_CYCLES = 16,
  parameter int CW = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sys_rst_o,
  input logic          irq_o,
  input logic          mask_q,
  input logic          sts_q,
  input logic          en_q,
  input logic          arm_q,
  input logic          gated,
  input logic          feed_ok,
  input logic [CW-1:0] count_q
);
  int hi_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= 0;
    else if (sys_rst_o) hi_run <= hi_run + 1;
    else                hi_run <= 0;
  end

  // R5
  rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |-> (hi_run < RST_CYCLES));

  // R8
  sticky_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_o) |-> sts_q);

  // R6
  ordered_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(arm_q));

  // R6
  stopped_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_q) |-> !$rose(sys_rst_o));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mask_q);

  // R11
  debug_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gated && !feed_ok) |=> $stable(count_q));

  // R11
  debug_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gated |=> !$rose(sys_rst_o));
endmodule

bind key_wdt key_wdt_chk #(.RST_CYCLES(RST_CYCLES), .CW(kwdt_pkg::CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sys_rst_o(sys_rst_o), .irq_o(irq_o),
  .mask_q(mask_q), .sts_q(sts_q), .en_q(en_q), .arm_q(arm_q),
  .gated(gated), .feed_ok(feed_ok), .count_q(count_q)
);

// File: tb/key_wdt_tb_top.sv
module key_wdt_tb_top;
  localparam int TICK = 4;
  localparam int RSTL = 3;
  localparam int DEFT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        dbg_mode = 1'b0;
  logic        irq_o, sys_rst_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  key_wdt #(.TICK_CYCLES(TICK), .RST_CYCLES(RSTL), .DEF_TIMEOUT(DEFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbg_mode(dbg_mode), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic stop_timer();
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'hCAFE);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0;
    int first_irq, hit, len;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h0C, v); chk("R1 stopped code", v, 16'hDABE);
    rd(6'h10, v); chk("R1 status", v, 0);
    rd(6'h14, v); chk("R1 count", v, 0);
    rd(6'h04, v); chk("R1 timeout", v, DEFT);
    chk("R1 irq", irq_o, 0);
    chk("R1 sys_rst", sys_rst_o, 0);

    // R3 timeout width
    wr(6'h04, 16'hFFFF);
    rd(6'h04, v); chk("R3 masked", v, 16'h7FFF);

    // R4 R5 R9 R10 sweep over timeouts
    for (int t = 1; t <= 6; t++) begin
      stop_timer();
      wr(6'h20, 16'h0001);
      wr(6'h24, 16'h0001);
      wr(6'h04, 16'(t));
      wr(6'h1C, 16'hACED);
      rd(6'h0C, v); chk("R7 resumed code", v, 0);
      wr(6'h00, 16'hFEED);
      rd(6'h14, v); chk("R2 loaded count", v, t);
      first_irq = -1; hit = -1;
      for (int i = 1; i <= t * TICK + 5; i++) begin
        step(1);
        if (i == 1) begin
          rd(6'h14, v); chk("R9 stable flag", v[15], 0);
        end
        if (i == TICK - 1) begin
          rd(6'h14, v); chk("R9 update flag", v[15], 1);
          chk("R9 count before tick", v[14:0], t);
        end
        if (irq_o && first_irq < 0) first_irq = i;
        if (sys_rst_o) begin hit = i; break; end
      end
      chk("R4 expiry edge", hit, t * TICK);
      chk("R10 warning edge", first_irq, (t >= 2) ? (t - 1) * TICK : -1);
      rd(6'h14, v); chk("R5 reload", v[14:0], t);
      rd(6'h10, v); chk("R8 timed out", v, 16'hCFE8);
      len = 1;
      for (int k = 0; k < 20; k++) begin
        step(1);
        if (!sys_rst_o) break;
        len++;
      end
      chk("R5 pulse width", len, RSTL);
    end

    // R8 clear keys
    wr(6'h10, 16'h1234);
    rd(6'h10, v); chk("R8 wrong clear", v, 16'hCFE8);
    stop_timer();
    wr(6'h10, 16'hE8B4);
    rd(6'h10, v); chk("R8 cleared", v, 0);

    // R2 wrong feed ignored, correct feed reloads
    wr(6'h04, 16'd6);
    wr(6'h1C, 16'hACED);
    wr(6'h00, 16'hFEED);
    step(2 * TICK);
    rd(6'h14, v); chk("R2 count after two ticks", v[14:0], 4);
    wr(6'h00, 16'h1234);
    step(TICK - 1);
    rd(6'h14, v); chk("R2 wrong feed ignored", v[14:0], 3);
    wr(6'h00, 16'hFEED);
    rd(6'h14, v); chk("R2 refeed", v[14:0], 6);

    // R6 lone and interrupted disable
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R6 lone second key", v, 0);
    wr(6'h08, 16'h2BAD);
    wr(6'h24, 16'h0000);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R6 interrupted pair", v, 0);
    wr(6'h08, 16'h2BAD);
    wr(6'h0C, 16'h1111);
    wr(6'h0C, 16'hCAFE);
    rd(6'h0C, v); chk("R6 wrong then right", v, 0);
    wr(6'h00, 16'hFEED);
    stop_timer();
    rd(6'h0C, v); chk("R6 stopped", v, 16'hDABE);

    // R2 feed while stopped; R7 idle after resume
    rd(6'h14, c0);
    wr(6'h00, 16'hFEED);
    step(3 * TICK);
    rd(6'h14, v); chk("R2 feed while stopped", v, c0);
    wr(6'h1C, 16'hACED);
    step(3 * TICK);
    rd(6'h14, v); chk("R7 idle until feed", v, c0);
    chk("R7 no reset", sys_rst_o, 0);

    // R10 force, mask, ack
    wr(6'h24, 16'h0000);
    wr(6'h28, 16'h0001);
    rd(6'h20, v); chk("R10 forced event", v, 1);
    chk("R10 masked irq", irq_o, 0);
    rd(6'h28, v); chk("R10 force reads zero", v, 0);
    wr(6'h24, 16'h0001);
    chk("R10 unmasked irq", irq_o, 1);
    wr(6'h20, 16'h0000);
    chk("R10 ack zero no effect", irq_o, 1);
    wr(6'h20, 16'h0001);
    chk("R10 acked", irq_o, 0);

    // R11 debug hold and override
    dbg_mode = 1'b1;
    wr(6'h04, 16'd2);
    wr(6'h00, 16'hFEED);
    rd(6'h18, v); chk("R11 debug read", v, 16'h0002);
    step(5 * TICK);
    rd(6'h14, v); chk("R11 held count", v[14:0], 2);
    chk("R11 no reset", sys_rst_o, 0);
    chk("R11 no warning", irq_o, 0);
    wr(6'h18, 16'h0001);
    rd(6'h18, v); chk("R11 override read", v, 16'h0003);
    hit = -1;
    for (int i = 1; i <= 3 * TICK; i++) begin
      step(1);
      if (sys_rst_o) begin hit = i; break; end
    end
    chk("R11 override expiry", hit, 2 * TICK);
    dbg_mode = 1'b0;
    stop_timer();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule